// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block takes a fast source clock and produces a slower output clock. A 4-bit ratio code sets the divide ratio. The two low code bits pick a small base divisor, and the two high code bits multiply that base by 1, 2, 4 or 8. A strap input chooses which of two base sets applies. All logic runs in the source clock domain, and the output comes from a register.

Each output has an enable bit, a phase-invert bit and an active-low power-down request. When the output is told to stop, it always finishes its visible high phase first and then rests low, so it never emits a shortened pulse. When the stop cause goes away, the output restarts with a full-length high phase. A status flag reports whenever the output is parked low.

Top module: `prog_clk_divider`

## Requirements
- R1: With `tbl_sel`=0 the ratio is B<<S, where S=`ratio_code[3:2]` and B is 2, 3, 5 or 7 for `ratio_code[1:0]` = 00, 01, 10 or 11. This covers /2 (code 0000) through /56 (code 1111).
- R2: With `tbl_sel`=1 the base divisors for `ratio_code[1:0]` = 00, 01, 10 and 11 are 4, 3, 5 and 9. This covers /3 (code 0001) through /72 (code 1111).
- R3: For a ratio N with inversion off, each output high phase lasts floor(N/2) source cycles and each low phase lasts N-floor(N/2) cycles. Even ratios therefore give 50% duty.
- R4: A change of `ratio_code` or `tbl_sel` takes effect only at the end of the output period in progress. The period in progress completes with the old high and low lengths.
- R5: With `out_inv`=1 the running output is the complement of the base waveform. The high phase lasts N-floor(N/2) cycles and the low phase lasts floor(N/2) cycles.
- R6: With `out_en`=0 the output finishes any visible high phase at full length, then goes low and stays low, and `stopped_o` is 1.
- R7: A power-down request takes effect only when `pd_n` is sampled low on two consecutive rising source edges. It then stops the output by the same rule as R6. A low lasting a single sample has no effect.
- R8: An output restart begins at the first rising edge where the stop cause is gone, with a full-length high phase and `stopped_o`=0. If `out_en` rises, the output is high right after the next edge. If `pd_n` is released, the output is high after the second edge.
- R9: While `rst_n` is low, `clk_div_o` is 0 and `stopped_o` is 1.
- R10: While `stopped_o` is 1, `clk_div_o` is 0 whatever the value of `out_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_code | input | 4 | Ratio code: [1:0] base select, [3:2] power-of-two scale |
| tbl_sel | input | 1 | Base-set strap: 0 = {2,3,5,7}, 1 = {4,3,5,9} |
| out_en | input | 1 | 1 = output runs, 0 = output parks low |
| out_inv | input | 1 | 1 = running output inverted |
| pd_n | input | 1 | Power-down request, active low |
| clk_div_o | output | 1 | Divided output clock |
| stopped_o | output | 1 | 1 while the output is parked low |

## Verification
Random codes, strap values and inversion settings are checked by measuring the high and low run lengths on the output pin. These measurements tell apart a wrong base divisor, a wrong scale shift, a wrong odd-ratio split and a wrong inverted duty. Directed cases cover the extreme ratios of both base sets (/2, /56, /3, /72). They also cover a code change made just after a rising output edge, which separates a load at the end of the period from an immediate reload.

Stop cases apply a disable or a power-down at the start of a high phase and again while the output is low. A single-sample power-down glitch is also applied. These cases separate a clean end-of-high stop from a truncated one, and a two-sample filter from a one-sample filter. Restart cases check the latency of the first high edge and the length of the first high phase after the stop cause is removed.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    typedef enum logic [1:0] {
        PH_STOP = 2'd0,
        PH_HI   = 2'd1,
        PH_LO   = 2'd2
    } phase_e;

    // Base divisor of one table entry; tbl 0 = {2,3,5,7}, tbl 1 = {4,3,5,9}
    function automatic int unsigned base_div(input int unsigned tbl, input int unsigned idx);
        int unsigned r;
        case (idx)
            0:       r = (tbl == 0) ? 2 : 4;
            1:       r = 3;
            2:       r = 5;
            default: r = (tbl == 0) ? 7 : 9;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcd_ratio_dec.sv
module pcd_ratio_dec #(
    parameter int BASE_BITS  = 2,
    parameter int SCALE_BITS = 2,
    parameter int RATIO_W    = 7
) (
    input  logic [BASE_BITS+SCALE_BITS-1:0] code_i,
    input  logic                            tbl_i,
    output logic [RATIO_W-1:0]              hi_len_o,
    output logic [RATIO_W-1:0]              lo_len_o
);
    import pcd_pkg::*;

    localparam int CODE_W = BASE_BITS + SCALE_BITS;
    localparam int N_TBL  = 2;
    localparam int N_BASE = 1 << BASE_BITS;

    logic [BASE_BITS-1:0]  base_idx;
    logic [SCALE_BITS-1:0] scale;
    logic [RATIO_W-1:0]    ratio_tbl [N_TBL];
    logic [RATIO_W-1:0]    ratio;

    assign base_idx = code_i[BASE_BITS-1:0];
    assign scale    = code_i[CODE_W-1:BASE_BITS];

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        logic [RATIO_W-1:0] base_lut [N_BASE];
        for (genvar b = 0; b < N_BASE; b++) begin : g_base
            assign base_lut[b] = RATIO_W'(base_div(t, b));
        end
        assign ratio_tbl[t] = base_lut[base_idx] << scale;
    end

    always_comb begin
        ratio    = tbl_i ? ratio_tbl[1] : ratio_tbl[0];
        hi_len_o = ratio >> 1;
        lo_len_o = ratio - (ratio >> 1);
    end

endmodule

// File: rtl/pcd_stop_ctl.sv
module pcd_stop_ctl #(
    parameter int PD_SAMPLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic pd_ni,
    output logic stop_req_o
);
    typedef struct packed {
        logic [PD_SAMPLES-1:0] pd_hist;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pd_hist = {st_q.pd_hist[PD_SAMPLES-2:0], pd_ni};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{pd_hist: '1};
        else         st_q <= st_d;
    end

    logic pd_req;
    assign pd_req     = (st_q.pd_hist == '0);
    assign stop_req_o = pd_req | ~en_i;

    // power-down request only after two low samples in a row
    AST_PD_TWO_SAMPLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pd_req) |-> (!$past(pd_ni) && !$past(pd_ni, 2))); // R7

endmodule

// File: rtl/pcd_div_core.sv
module pcd_div_core #(
    parameter int RATIO_W = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] new_hi_i,
    input  logic [RATIO_W-1:0] new_lo_i,
    input  logic               inv_i,
    input  logic               stop_req_i,
    output logic               out_o,
    output logic               stopped_o
);
    import pcd_pkg::*;

    typedef struct packed {
        phase_e             phase;
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] hi_len;
        logic [RATIO_W-1:0] lo_len;
        logic               out;
        logic               stopped;
    } core_t;

    core_t c_d, c_q;
    logic  nvis;

    always_comb begin
        c_d  = c_q;
        nvis = c_q.out;
        case (c_q.phase)
            PH_STOP: begin
                if (!stop_req_i) begin
                    c_d.hi_len  = new_hi_i;
                    c_d.lo_len  = new_lo_i;
                    c_d.out     = 1'b1;
                    c_d.stopped = 1'b0;
                    if (inv_i) begin
                        c_d.phase = PH_LO;
                        c_d.cnt   = new_lo_i - 1'b1;
                    end else begin
                        c_d.phase = PH_HI;
                        c_d.cnt   = new_hi_i - 1'b1;
                    end
                end
            end
            PH_HI: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    c_d.phase = PH_LO;
                    c_d.cnt   = c_q.lo_len - 1'b1;
                end
            end
            default: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else begin
                    // period boundary: pick up the current code
                    c_d.phase  = PH_HI;
                    c_d.hi_len = new_hi_i;
                    c_d.lo_len = new_lo_i;
                    c_d.cnt    = new_hi_i - 1'b1;
                end
            end
        endcase

        if (c_q.phase != PH_STOP) begin
            nvis    = (c_d.phase == PH_HI) ^ inv_i;
            c_d.out = nvis;
            // park unless the visible output is high and stays high
            if (stop_req_i && !(c_q.out && nvis)) begin
                c_d.phase   = PH_STOP;
                c_d.cnt     = '0;
                c_d.out     = 1'b0;
                c_d.stopped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '{phase: PH_STOP, cnt: '0, hi_len: '0, lo_len: '0,
                     out: 1'b0, stopped: 1'b1};
        end else begin
            c_q <= c_d;
        end
    end

    assign out_o     = c_q.out;
    assign stopped_o = c_q.stopped;

    AST_HI_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.phase == PH_HI) |-> (c_q.cnt < c_q.hi_len)); // R3

    AST_LO_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.phase == PH_LO) |-> (c_q.cnt < c_q.lo_len)); // R3

    AST_RATIO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.phase == PH_HI) |=> ($stable(c_q.hi_len) && $stable(c_q.lo_len))); // R4

    AST_STOP_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(c_q.stopped) && $past(c_q.out)) |-> ($past(c_q.cnt) == '0)); // R6

    AST_RESTART_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(c_q.stopped) |-> c_q.out); // R8

endmodule

// File: rtl/prog_clk_divider.sv
module prog_clk_divider #(
    parameter int BASE_BITS  = 2,
    parameter int SCALE_BITS = 2,
    parameter int RATIO_W    = 7,
    parameter int PD_SAMPLES = 2
) (
    input  logic       clk_src,
    input  logic       rst_n,
    input  logic [3:0] ratio_code,
    input  logic       tbl_sel,
    input  logic       out_en,
    input  logic       out_inv,
    input  logic       pd_n,
    output logic       clk_div_o,
    output logic       stopped_o
);
    logic [RATIO_W-1:0] new_hi, new_lo;
    logic               stop_req;

    pcd_ratio_dec #(
        .BASE_BITS (BASE_BITS),
        .SCALE_BITS(SCALE_BITS),
        .RATIO_W   (RATIO_W)
    ) u_dec (
        .code_i  (ratio_code[BASE_BITS+SCALE_BITS-1:0]),
        .tbl_i   (tbl_sel),
        .hi_len_o(new_hi),
        .lo_len_o(new_lo)
    );

    pcd_stop_ctl #(
        .PD_SAMPLES(PD_SAMPLES)
    ) u_stop (
        .clk_i     (clk_src),
        .rst_ni    (rst_n),
        .en_i      (out_en),
        .pd_ni     (pd_n),
        .stop_req_o(stop_req)
    );

    pcd_div_core #(
        .RATIO_W(RATIO_W)
    ) u_core (
        .clk_i     (clk_src),
        .rst_ni    (rst_n),
        .new_hi_i  (new_hi),
        .new_lo_i  (new_lo),
        .inv_i     (out_inv),
        .stop_req_i(stop_req),
        .out_o     (clk_div_o),
        .stopped_o (stopped_o)
    );

    AST_PARKED_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
        stopped_o |-> !clk_div_o); // R10

    AST_DISABLE_PARKS: assert property (@(posedge clk_src) disable iff (!rst_n)
        ($past(!out_en) && $past(!clk_div_o)) |-> stopped_o); // R6

endmodule

// File: tb/prog_clk_divider_test.sv
module prog_clk_divider_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ratio_code;
    logic       tbl_sel, out_en, out_inv, pd_n;
    logic       clk_div_o, stopped_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_clk_divider uut (
        .clk_src(clk), .rst_n(rst_n), .ratio_code(ratio_code), .tbl_sel(tbl_sel),
        .out_en(out_en), .out_inv(out_inv), .pd_n(pd_n),
        .clk_div_o(clk_div_o), .stopped_o(stopped_o)
    );

    function automatic int exp_ratio(input logic tbl, input logic [3:0] code);
        int b;
        case (code[1:0])
            2'd0:    b = tbl ? 4 : 2;
            2'd1:    b = 3;
            2'd2:    b = 5;
            default: b = tbl ? 9 : 7;
        endcase
        return b << code[3:2];
    endfunction

    function automatic int exp_hi(input int n, input logic inv);
        return inv ? (n - n / 2) : (n / 2);
    endfunction

    function automatic int exp_lo(input int n, input logic inv);
        return inv ? (n / 2) : (n - n / 2);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_rise();
        while (clk_div_o !== 1'b0) @(negedge clk);
        while (clk_div_o !== 1'b1) @(negedge clk);
    endtask

    task automatic count_run(input logic lvl, output int n);
        n = 0;
        while (clk_div_o === lvl && n < 400) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure(input string req, input int n_exp, input logic inv);
        int h, l;
        wait_rise();
        count_run(1'b1, h);
        count_run(1'b0, l);
        check(h == exp_hi(n_exp, inv), {req, " high run"}, h, exp_hi(n_exp, inv));
        check(l == exp_lo(n_exp, inv), {req, " low run"}, l, exp_lo(n_exp, inv));
    endtask

    task automatic setup(input logic tbl, input logic [3:0] code, input logic inv);
        tbl_sel = tbl; ratio_code = code; out_inv = inv;
        cyc(2 * 72 + 4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int h, l;
        logic [3:0] rc;
        logic rt, ri;
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; ratio_code = 4'd0; tbl_sel = 1'b0;
        out_en = 1'b1; out_inv = 1'b0; pd_n = 1'b1;
        cyc(3);
        // R9 reset state
        check(clk_div_o === 1'b0, "R9 out in reset", int'(clk_div_o), 0);
        check(stopped_o === 1'b1, "R9 flag in reset", int'(stopped_o), 1);
        rst_n = 1'b1;

        // R1 / R2 extremes, R3 odd split
        setup(1'b0, 4'b0000, 1'b0); measure("R1 /2", 2, 1'b0);
        setup(1'b0, 4'b1111, 1'b0); measure("R1 /56", 56, 1'b0);
        setup(1'b0, 4'b0011, 1'b0); measure("R3 /7 odd", 7, 1'b0);
        setup(1'b1, 4'b0001, 1'b0); measure("R2 /3", 3, 1'b0);
        setup(1'b1, 4'b1111, 1'b0); measure("R2 /72", 72, 1'b0);
        setup(1'b1, 4'b0000, 1'b0); measure("R2 /4", 4, 1'b0);
        setup(1'b1, 4'b0111, 1'b1); measure("R5 /18 inverted", 18, 1'b1);
        setup(1'b0, 4'b0001, 1'b1); measure("R5 /3 inverted", 3, 1'b1);

        // random mix
        for (int k = 0; k < 24; k++) begin
            rc = 4'($urandom_range(0, 15));
            rt = 1'($urandom_range(0, 1));
            ri = 1'($urandom_range(0, 1));
            setup(rt, rc, ri);
            measure(ri ? "R5 random" : (rt ? "R2 random" : "R1 random"),
                    exp_ratio(rt, rc), ri);
        end

        // R4: change code right after a rising output edge
        setup(1'b0, 4'b1111, 1'b0);
        wait_rise();
        ratio_code = 4'b0000;
        count_run(1'b1, h);
        count_run(1'b0, l);
        check(h == 28, "R4 old high kept", h, 28);
        check(l == 28, "R4 old low kept", l, 28);
        count_run(1'b1, h);
        check(h == 1, "R4 new ratio next period", h, 1);

        // R6: disable at start of high phase, /7 (high 3)
        setup(1'b0, 4'b0011, 1'b0);
        wait_rise();
        out_en = 1'b0;
        count_run(1'b1, h);
        check(h == 3, "R6 high finishes full", h, 3);
        cyc(1);
        check(stopped_o === 1'b1, "R6 flag set", int'(stopped_o), 1);
        l = 0;
        for (int i = 0; i < 30; i++) begin
            if (clk_div_o !== 1'b0) l++;
            @(negedge clk);
        end
        check(l == 0, "R6 stays low", l, 0);
        // R8: enable restart latency and full high phase
        out_en = 1'b1;
        @(negedge clk);
        check(clk_div_o === 1'b1, "R8 high after one edge", int'(clk_div_o), 1);
        check(stopped_o === 1'b0, "R8 flag cleared", int'(stopped_o), 0);
        count_run(1'b1, h);
        check(h == 3, "R8 full first high", h, 3);

        // R6: disable while low parks on the next edge
        while (clk_div_o !== 1'b0) @(negedge clk);
        out_en = 1'b0;
        @(negedge clk);
        check(stopped_o === 1'b1, "R6 park from low", int'(stopped_o), 1);
        out_en = 1'b1;
        cyc(20);

        // R7: single-sample glitch has no effect
        pd_n = 1'b0;
        @(negedge clk);
        pd_n = 1'b1;
        l = 0;
        for (int i = 0; i < 20; i++) begin
            if (stopped_o !== 1'b0) l++;
            @(negedge clk);
        end
        check(l == 0, "R7 glitch ignored", l, 0);

        // R7: held low stops at end of high phase
        wait_rise();
        pd_n = 1'b0;
        count_run(1'b1, h);
        check(h == 3, "R7 high finishes full", h, 3);
        cyc(2);
        check(stopped_o === 1'b1, "R7 flag set", int'(stopped_o), 1);
        cyc(20);
        check(clk_div_o === 1'b0, "R7 held low", int'(clk_div_o), 0);
        // R8: power-down release, high after second edge
        pd_n = 1'b1;
        @(negedge clk);
        check(clk_div_o === 1'b0, "R8 still low after one edge", int'(clk_div_o), 0);
        @(negedge clk);
        check(clk_div_o === 1'b1, "R8 high after two edges", int'(clk_div_o), 1);
        count_run(1'b1, h);
        check(h == 3, "R8 full high after power-down", h, 3);

        // R10: stopped output low with inversion on
        setup(1'b0, 4'b0011, 1'b1);
        out_en = 1'b0;
        cyc(20);
        check(clk_div_o === 1'b0, "R10 inverted parked low", int'(clk_div_o), 0);
        check(stopped_o === 1'b1, "R10 flag", int'(stopped_o), 1);
        out_en = 1'b1;
        @(negedge clk);
        count_run(1'b1, h);
        check(h == 4, "R8 inverted restart full high", h, 4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule